// File: doc/BRIEF.md
# Serial Flash Sleep-Mode Controller

This block is the power-mode state machine of a serial flash slave. It watches a mode-0 SPI bus (clock idle low, data taken on the rising clock edge and launched on the falling edge) and picks out two single-byte instructions: a sleep opcode and a wake opcode. A sleep frame is acted on only when chip select rises exactly after its eighth bit and no program, erase or write cycle is busy. The block then waits a programmed number of clock cycles before it reports the low-power state. The only way out of that state is the wake opcode, followed by a programmed settling delay before it returns to standby.

While the block is not in standby, an instruction-gate output is held low. The main command decoder uses this gate so that it ignores write, program and erase requests, or any other opcode. When the wake opcode is followed by three dummy bytes, a fixed 8-bit signature is sent back on the serial output. It is sent MSB first and repeats for as long as chip select stays low. The SPI pins are sampled with the block clock and are assumed to be synchronised to it already.

Top module: `fsc_top`

## Requirements
- R1: After reset, pwr_mode is 0 (standby), cmd_gate is 1, lowpwr_en is 0 and spi_miso_oe is 0.
- R2: A frame whose first byte is 0xB9 (MSB first), ended by chip select rising after exactly 8 clock edges, puts pwr_mode at 1 (entering) for exactly ENTRY_CYC cycles, then at 2 (asleep) with lowpwr_en high.
- R3: A 0xB9 frame ended after any bit count other than 8 (for example 7, 9 or 16) leaves the block in standby.
- R4: A 0xB9 frame that ends while busy_i is high is rejected, and the block stays in standby.
- R5: While asleep, every opcode except 0xAB, including 0xB9 and all write, program and erase codes, leaves pwr_mode at 2.
- R6: While asleep, a frame whose first byte is 0xAB and that is ended after 8 or more bits puts pwr_mode at 3 (waking) for exactly WAKE_CYC cycles, then back at 0. A frame with fewer than 8 bits is ignored.
- R7: cmd_gate is high only in standby and low in entering, asleep and waking. lowpwr_en is high only when asleep.
- R8: In standby or asleep, an 0xAB frame followed by 24 dummy bits drives spi_miso with SIG on falling clock edges, MSB first. The signature repeats every 8 bits while chip select stays low, spi_miso_oe is high while it is driven, and spi_miso_oe is low after deselect.
- R9: Frames that end while entering or waking are ignored: a wake frame does not cut short the entry, and a sleep frame does not stop the return to standby.
- R10: Toggling chip select with no clock edges never leaves standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| busy_i | input | 1 | Program/erase/write engine busy |
| spi_miso | output | 1 | SPI serial data out (signature) |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| lowpwr_en | output | 1 | High while asleep |
| cmd_gate | output | 1 | High when the main decoder may act on opcodes |
| pwr_mode | output | 2 | 0 standby, 1 entering, 2 asleep, 3 waking |

## Verification
The hardest situations to reach are frames that finish inside the short entering and waking windows, because a full SPI frame normally takes longer than those windows last. The bench therefore uses long entry and wake delays and starts a second frame right after the first one is deselected, so that the second frame ends while the transition is still running. Bit-count edge cases are covered by sweeping the frame length, and opcode filtering is covered by sweeping all 256 opcodes both in standby and while asleep.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY  = 2'd0,
        PM_ENTERING = 2'd1,
        PM_ASLEEP   = 2'd2,
        PM_WAKING   = 2'd3
    } pm_state_e;

    localparam logic [7:0] OPC_SLEEP = 8'hB9;
    localparam logic [7:0] OPC_WAKE  = 8'hAB;

    localparam int PHASE_W    = 3;
    localparam int BYTES_W    = 3;
    localparam int LEAD_BYTES = 4;   // opcode plus three dummy bytes

    typedef struct packed {
        logic               done;     // chip-select rising this cycle
        logic               opc_ok;   // first byte complete
        logic [7:0]         opcode;
        logic [BYTES_W-1:0] bytes;    // saturating count of whole bytes
        logic [PHASE_W-1:0] phase;    // bits into current byte
    } frame_info_t;

    function automatic logic is_sleep_frame(frame_info_t f);
        return f.done && f.opc_ok && (f.opcode == OPC_SLEEP) &&
               (f.bytes == BYTES_W'(1)) && (f.phase == '0);
    endfunction

    function automatic logic is_wake_frame(frame_info_t f);
        return f.done && f.opc_ok && (f.opcode == OPC_WAKE);
    endfunction

endpackage

// File: rtl/fsc_spi_rx.sv
module fsc_spi_rx
    import fsc_pkg::*;
#(
    parameter int BYTE_SAT = LEAD_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output frame_info_t info,
    output logic        sck_fall,
    output logic        sel
);
    localparam logic [BYTES_W-1:0] SAT = BYTES_W'(BYTE_SAT);

    logic sck_q, sck_qq, cs_q, cs_qq, mosi_q;
    logic [7:0]         shreg;
    logic [7:0]         opcode;
    logic               opc_ok;
    logic [BYTES_W-1:0] bytes;
    logic [PHASE_W-1:0] phase;
    logic               sck_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            sck_qq <= 1'b0;
            cs_q   <= 1'b1;
            cs_qq  <= 1'b1;
            mosi_q <= 1'b0;
        end else begin
            sck_q  <= spi_sck;
            sck_qq <= sck_q;
            cs_q   <= spi_cs_n;
            cs_qq  <= cs_q;
            mosi_q <= spi_mosi;
        end
    end

    assign sck_rise = sck_q & ~sck_qq & ~cs_q;
    assign sck_fall = ~sck_q & sck_qq & ~cs_q;
    assign sel      = ~cs_q;

    always_ff @(posedge clk) begin
        if (rst || cs_q) begin
            shreg  <= '0;
            opcode <= '0;
            opc_ok <= 1'b0;
            bytes  <= '0;
            phase  <= '0;
        end else if (sck_rise) begin
            shreg <= {shreg[6:0], mosi_q};
            phase <= phase + 1'b1;
            if (phase == PHASE_W'(7)) begin
                if (bytes != SAT) bytes <= bytes + 1'b1;
                if (!opc_ok) begin
                    opcode <= {shreg[6:0], mosi_q};
                    opc_ok <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        info.done   = cs_q & ~cs_qq;
        info.opc_ok = opc_ok;
        info.opcode = opcode;
        info.bytes  = bytes;
        info.phase  = phase;
    end

endmodule

// File: rtl/fsc_mode_fsm.sv
module fsc_mode_fsm
    import fsc_pkg::*;
#(
    parameter int ENTRY_CYC = 6,
    parameter int WAKE_CYC  = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  frame_info_t info,
    input  logic        busy_i,
    output pm_state_e   state
);
    localparam int MAXC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] WAKE_LD  = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PM_STANDBY;
            cnt   <= '0;
        end else begin
            unique case (state)
                PM_STANDBY: begin
                    if (is_sleep_frame(info) && !busy_i) begin
                        state <= PM_ENTERING;
                        cnt   <= ENTRY_LD;
                    end
                end
                PM_ENTERING: begin
                    if (cnt == '0) state <= PM_ASLEEP;
                    else           cnt   <= cnt - 1'b1;
                end
                PM_ASLEEP: begin
                    if (is_wake_frame(info)) begin
                        state <= PM_WAKING;
                        cnt   <= WAKE_LD;
                    end
                end
                PM_WAKING: begin
                    if (cnt == '0) state <= PM_STANDBY;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= PM_STANDBY;
            endcase
        end
    end

endmodule

// File: rtl/fsc_sig_tx.sv
module fsc_sig_tx
    import fsc_pkg::*;
#(
    parameter logic [7:0] SIG = 8'hC3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               sck_fall,
    input  logic               wake_op,
    input  logic               lead_done,
    input  logic               allow,
    input  logic [PHASE_W-1:0] phase,
    output logic               miso,
    output logic               miso_oe
);
    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else if (sck_fall && wake_op && lead_done && allow) begin
            miso    <= SIG[PHASE_W'(7) - phase];
            miso_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/fsc_top.sv
module fsc_top
    import fsc_pkg::*;
#(
    parameter int         ENTRY_CYC = 6,
    parameter int         WAKE_CYC  = 5,
    parameter logic [7:0] SIG       = 8'hC3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    input  logic       busy_i,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    output logic       lowpwr_en,
    output logic       cmd_gate,
    output logic [1:0] pwr_mode
);
    frame_info_t info;
    logic        sck_fall, sel;
    pm_state_e   state;
    logic        wake_op, lead_done, allow;

    fsc_spi_rx #(.BYTE_SAT(LEAD_BYTES)) u_rx (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .info(info), .sck_fall(sck_fall), .sel(sel)
    );

    fsc_mode_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .info(info), .busy_i(busy_i), .state(state)
    );

    assign wake_op   = info.opc_ok && (info.opcode == OPC_WAKE);
    assign lead_done = (info.bytes >= BYTES_W'(LEAD_BYTES));
    assign allow     = (state == PM_STANDBY) || (state == PM_ASLEEP);

    fsc_sig_tx #(.SIG(SIG)) u_sig (
        .clk(clk), .rst(rst), .sel(sel), .sck_fall(sck_fall),
        .wake_op(wake_op), .lead_done(lead_done), .allow(allow),
        .phase(info.phase), .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    assign pwr_mode  = state;
    assign lowpwr_en = (state == PM_ASLEEP);
    assign cmd_gate  = (state == PM_STANDBY);

endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
    parameter int ENTRY_CYC = 6,
    parameter int WAKE_CYC  = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       busy_i,
    input logic [1:0] pwr_mode,
    input logic       lowpwr_en,
    input logic       cmd_gate
);
    int ent_cnt;
    int wak_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_cnt <= 0;
            wak_cnt <= 0;
        end else begin
            ent_cnt <= (pwr_mode == 2'd1) ? ent_cnt + 1 : 0;
            wak_cnt <= (pwr_mode == 2'd3) ? wak_cnt + 1 : 0;
        end
    end

    p_entry_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd1) |-> (ent_cnt < ENTRY_CYC));
    p_entry_done_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd1 && ent_cnt == ENTRY_CYC - 1) |=> (pwr_mode == 2'd2));
    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd1 && $past(pwr_mode) == 2'd0) |-> !$past(busy_i));
    p_asleep_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2) |=> (pwr_mode == 2'd2 || pwr_mode == 2'd3));
    p_wake_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd3) |-> (wak_cnt < WAKE_CYC));
    p_gate_excl_r7: assert property (@(posedge clk) disable iff (rst)
        lowpwr_en |-> !cmd_gate);
    p_no_direct_sleep_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd0) |=> (pwr_mode == 2'd0 || pwr_mode == 2'd1));

endmodule

bind fsc_top fsc_chk #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy_i(busy_i), .pwr_mode(pwr_mode),
    .lowpwr_en(lowpwr_en), .cmd_gate(cmd_gate)
);

// File: tb/test_fsc_top.sv
`timescale 1ns/1ps
module test_fsc_top;
    localparam int         ENTRY_CYC = 100;
    localparam int         WAKE_CYC  = 60;
    localparam logic [7:0] SIG       = 8'hC3;
    localparam int         HALF      = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, busy_i = 1'b0;
    logic spi_miso, spi_miso_oe, lowpwr_en, cmd_gate;
    logic [1:0] pwr_mode;
    logic [63:0] rxb;
    int n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    fsc_top #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC), .SIG(SIG)) i_fsc_top (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .busy_i(busy_i), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .lowpwr_en(lowpwr_en), .cmd_gate(cmd_gate),
        .pwr_mode(pwr_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits);
        rxb = '0;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 8) ? op[7-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 64) rxb[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_mode(input logic [1:0] m);
        for (int k = 0; k < 400 && pwr_mode != m; k++) @(negedge clk);
    endtask

    task automatic go_sleep();
        xfer(8'hB9, 8);
        wait_mode(2'd2);
    endtask

    task automatic go_wake();
        xfer(8'hAB, 8);
        wait_mode(2'd0);
    endtask

    task automatic count_in(input logic [1:0] m, output int d);
        d = 0;
        while (pwr_mode == m && d < 1000) begin
            d++;
            @(negedge clk);
        end
    endtask

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(pwr_mode == 2'd0, "R1", "pwr_mode", pwr_mode, 0);
        chk(cmd_gate == 1'b1, "R1", "cmd_gate", cmd_gate, 1);
        chk(lowpwr_en == 1'b0, "R1", "lowpwr_en", lowpwr_en, 0);
        chk(spi_miso_oe == 1'b0, "R1", "spi_miso_oe", spi_miso_oe, 0);

        // R10 chip-select toggles without clocks
        for (int k = 0; k < 5; k++) begin
            spi_cs_n = 1'b0; repeat (3) @(negedge clk);
            spi_cs_n = 1'b1; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(pwr_mode == 2'd0, "R10", "mode after bare deselects", pwr_mode, 0);

        // R2 and R7 entry timing and gating
        xfer(8'hB9, 8);
        chk(pwr_mode == 2'd1, "R2", "mode after sleep frame", pwr_mode, 1);
        chk(cmd_gate == 1'b0, "R7", "cmd_gate entering", cmd_gate, 0);
        chk(lowpwr_en == 1'b0, "R7", "lowpwr_en entering", lowpwr_en, 0);
        count_in(2'd1, d);
        chk(d == ENTRY_CYC, "R2", "entering length", d, ENTRY_CYC);
        chk(pwr_mode == 2'd2, "R2", "mode after entry", pwr_mode, 2);
        chk(lowpwr_en == 1'b1, "R2", "lowpwr_en asleep", lowpwr_en, 1);
        chk(cmd_gate == 1'b0, "R7", "cmd_gate asleep", cmd_gate, 0);

        // R6 and R7 wake timing
        xfer(8'hAB, 8);
        chk(pwr_mode == 2'd3, "R6", "mode after wake frame", pwr_mode, 3);
        chk(cmd_gate == 1'b0, "R7", "cmd_gate waking", cmd_gate, 0);
        count_in(2'd3, d);
        chk(d == WAKE_CYC, "R6", "waking length", d, WAKE_CYC);
        chk(pwr_mode == 2'd0, "R6", "mode after wake", pwr_mode, 0);
        chk(cmd_gate == 1'b1 && lowpwr_en == 1'b0, "R7", "gate in standby",
            {cmd_gate, lowpwr_en}, 2);

        // R3 sleep frame bit-count sweep
        for (int n = 1; n <= 20; n++) begin
            xfer(8'hB9, n);
            repeat (2) @(negedge clk);
            if (n == 8) begin
                chk(pwr_mode == 2'd1, "R3", $sformatf("sleep len %0d", n), pwr_mode, 1);
                wait_mode(2'd2);
                go_wake();
            end else begin
                chk(pwr_mode == 2'd0, "R3", $sformatf("sleep len %0d", n), pwr_mode, 0);
            end
        end

        // R4 busy rejection
        busy_i = 1'b1;
        xfer(8'hB9, 8);
        repeat (4) @(negedge clk);
        chk(pwr_mode == 2'd0, "R4", "sleep while busy", pwr_mode, 0);
        busy_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(pwr_mode == 2'd0, "R4", "after busy drops", pwr_mode, 0);

        // standby opcode sweep: only 0xB9 starts entry
        for (int op = 0; op < 256; op++) begin
            xfer(op[7:0], 8);
            repeat (2) @(negedge clk);
            if (op == 8'hB9) begin
                chk(pwr_mode == 2'd1, "R2", $sformatf("standby op %02h", op), pwr_mode, 1);
                wait_mode(2'd2);
                go_wake();
            end else begin
                chk(pwr_mode == 2'd0, "R2", $sformatf("standby op %02h", op), pwr_mode, 0);
            end
        end

        // R5 asleep opcode sweep
        go_sleep();
        for (int op = 0; op < 256; op++) begin
            xfer(op[7:0], 8);
            repeat (2) @(negedge clk);
            if (op == 8'hAB) begin
                chk(pwr_mode == 2'd3, "R6", $sformatf("asleep op %02h", op), pwr_mode, 3);
                wait_mode(2'd0);
                go_sleep();
            end else begin
                chk(pwr_mode == 2'd2, "R5", $sformatf("asleep op %02h", op), pwr_mode, 2);
            end
        end

        // R6 wake frame bit-count sweep (still asleep here)
        for (int n = 1; n <= 16; n++) begin
            xfer(8'hAB, n);
            repeat (2) @(negedge clk);
            if (n >= 8) begin
                chk(pwr_mode == 2'd3, "R6", $sformatf("wake len %0d", n), pwr_mode, 3);
                wait_mode(2'd0);
                go_sleep();
            end else begin
                chk(pwr_mode == 2'd2, "R6", $sformatf("wake len %0d", n), pwr_mode, 2);
            end
        end
        go_wake();

        // R9 wake frame during entry, sleep frame during waking
        xfer(8'hB9, 8);
        xfer(8'hAB, 8);
        repeat (2) @(negedge clk);
        chk(pwr_mode == 2'd1, "R9", "wake during entry", pwr_mode, 1);
        wait_mode(2'd2);
        chk(pwr_mode == 2'd2, "R9", "entry completes", pwr_mode, 2);
        xfer(8'hAB, 8);
        xfer(8'hB9, 8);
        wait_mode(2'd0);
        repeat (20) @(negedge clk);
        chk(pwr_mode == 2'd0, "R9", "sleep during waking", pwr_mode, 0);

        // R8 signature in standby and asleep
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) go_sleep();
            xfer(8'hAB, 56);
            for (int b = 32; b < 56; b++)
                chk(rxb[b] == SIG[7 - (b % 8)], "R8",
                    $sformatf("sig bit %0d pass %0d", b, pass), rxb[b], SIG[7 - (b % 8)]);
            chk(rxb[31:0] == 32'h0, "R8", "no output before lead", int'(rxb[31:0]), 0);
            chk(spi_miso_oe == 1'b0, "R8", "oe after deselect", spi_miso_oe, 0);
            wait_mode(2'd0);
        end
        chk(pwr_mode == 2'd0, "R8", "standby after signature wake", pwr_mode, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule